// File: doc/BRIEF.md
# Masked-Write PHY Configuration Bank

This block holds the static and slow-changing controls of an eMMC-style I/O PHY: tap delays for the transmit and receive paths, the DLL frequency band, per-line pull and open-drain enables, drive strength, charge-pump trim, retention, DLL enable and the power control. Software reaches it through a plain memory-mapped port with a byte address, a write strobe, 32-bit write data, a read strobe and registered read data. Every control field is brought out as its own output port so the analog side needs no decoding.

Writes never need a read-modify-write. Each write carries its own mask in the upper half-word. Bit n of the lower half of the addressed register takes the written value only when bit n+16 of the same write is 1. Different agents can therefore change disjoint fields without locking. A read-only status word collects calibration, DLL and resistor-trim state from input ports.

Top module: `phycfg_bank`

## Requirements
- R1: After reset every control output is 0, so the PHY is powered down (`pwr_up_o`=0) and the DLL is off (`dll_en_o`=0), and every control register reads back 0.
- R2: A write to a control register changes stored bit n (n<16) to write-data bit n only when write-data bit n+16 is 1; all other stored bits keep their value.
- R3: A write whose upper 16 bits are all 0 leaves the addressed register unchanged.
- R4: A control register reads back as 0 in bits 31:16 and its stored value in bits 15:0; bits with no field read 0 even after being written with 1.
- R5: `rdata_o` takes the value of the address presented with `re_i` at the next rising clock edge and holds it while `re_i` is low. A read in the same cycle as a write to the same register returns the value from before the write.
- R6: Offset 0x20 reads as: bit 6 calibration done, bit 5 DLL ready, bits 4:1 resistor trim code, bit 0 external resistor absent, all other bits 0.
- R7: Writes to offset 0x20 change no control register and no control output.
- R8: Offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x20, including addresses whose low two bits are not 0, read as 0, and writes to them are ignored.
- R9: Offset 0x00 fields: bits 13:12 frequency band (0=200M, 1=50M, 2=100M, 3=150M), bit 11 output tap enable, bits 10:7 output tap select, bit 6 input tap change window, bits 5:1 input tap select, bit 0 input tap enable.
- R10: Offset 0x18 fields: bits 12:9 charge-pump trim, bit 8 retrim enable, bit 7 retrim, bits 6:4 drive type, bits 3:2 retention controls, bit 1 DLL enable, bit 0 power-up (1 = powered).
- R11: Offsets 0x08 (pull enable), 0x0C (pull-up), 0x14 (open-drain enable) hold strobe in bit 9, command in bit 8, data lines in bits 7:0. Offset 0x10 (open-drain release) holds command in bit 9, strobe in bit 8, data lines in bits 7:0.
- R12: Offset 0x04 fields: bits 8:6 clock buffer select, bit 5 delayed transmit clock select, bit 4 delayed receive clock select, bits 3:0 strobe delay select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data, upper half is bit mask |
| re_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Registered read data |
| cal_done_i | input | 1 | Calibration complete |
| dll_lock_i | input | 1 | DLL ready |
| rtrim_code_i | input | 4 | Resistor trim code |
| ext_res_absent_i | input | 1 | External resistor not fitted |
| freq_sel_o | output | 2 | DLL frequency band |
| otap_en_o | output | 1 | Output tap delay enable |
| otap_sel_o | output | 4 | Output tap delay select |
| itap_win_o | output | 1 | Input tap change window |
| itap_sel_o | output | 5 | Input tap delay select |
| itap_en_o | output | 1 | Input tap delay enable |
| clkbuf_sel_o | output | 3 | Clock buffer select |
| tx_dly_clk_o | output | 1 | Delayed transmit clock select |
| rx_dly_clk_o | output | 1 | Delayed receive clock select |
| strb_dly_sel_o | output | 4 | Strobe delay select |
| pull_en_strb_o | output | 1 | Strobe pull enable |
| pull_en_cmd_o | output | 1 | Command pull enable |
| pull_en_dat_o | output | 8 | Data pull enables |
| pull_up_strb_o | output | 1 | Strobe pull-up |
| pull_up_cmd_o | output | 1 | Command pull-up |
| pull_up_dat_o | output | 8 | Data pull-ups |
| od_rel_strb_o | output | 1 | Strobe open-drain release |
| od_rel_cmd_o | output | 1 | Command open-drain release |
| od_rel_dat_o | output | 8 | Data open-drain release |
| od_en_strb_o | output | 1 | Strobe open-drain enable |
| od_en_cmd_o | output | 1 | Command open-drain enable |
| od_en_dat_o | output | 8 | Data open-drain enable |
| cp_trim_o | output | 4 | DLL charge-pump trim |
| rtrim_en_o | output | 1 | Resistor retrim enable |
| retrim_o | output | 1 | Retrim request |
| drv_type_o | output | 3 | Drive strength type |
| ret_ctl_o | output | 2 | Retention controls |
| dll_en_o | output | 1 | DLL enable |
| pwr_up_o | output | 1 | PHY power-up (0 = powered down) |

## Verification
The bench goes after partial masks. A design that treats the write as a plain store, or that shifts the mask by the wrong amount, clears or sets fields that the mask leaves alone. It writes an all-ones pattern to the offset 0x04 register to show that bits with no field stay 0, and it uses the swapped command/strobe positions at 0x10 to catch a register copied from its neighbours. It also targets misaligned and unmapped addresses, which a decoder that drops the low address bits would alias onto real registers. A read in the same cycle as a write must return the old value, and the status offset must absorb writes.

// File: rtl/phycfg_pkg.sv
package phycfg_pkg;
  localparam int DW        = 32;
  localparam int HALF      = DW / 2;
  localparam int NUM_CTRL  = 7;
  localparam int STAT_IDX  = 8;

  typedef logic [HALF-1:0] half_t;

  // implemented width of each control register, fields start at bit 0
  function automatic int ctrl_width(input int idx);
    case (idx)
      0:       return 14;
      1:       return 9;
      6:       return 13;
      default: return 10;
    endcase
  endfunction
endpackage

// File: rtl/hiword_reg.sv
module hiword_reg #(
  parameter int W = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [31:0]   wdata_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] mask, data;
  assign mask = wdata_i[16 +: W];
  assign data = wdata_i[W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= (q_o & ~mask) | (data & mask);
  end

  a_r2_unmasked_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((q_o ^ $past(q_o)) & ~$past(mask)) == '0);
  a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(q_o));
  a_r3_empty_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && mask == '0) |=> $stable(q_o));
endmodule

// File: rtl/phycfg_decode.sv
module phycfg_decode #(
  parameter int AW = 6,
  parameter int NC = 7,
  parameter int SI = 8
) (
  input  logic [AW-1:0] addr_i,
  output logic [NC-1:0] ctrl_sel_o,
  output logic          stat_sel_o
);
  localparam int IW = AW - 2;
  logic [IW-1:0] idx;
  logic          aligned;

  assign idx     = addr_i[AW-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar i = 0; i < NC; i++) begin : g_sel
    assign ctrl_sel_o[i] = aligned && (idx == IW'(i));
  end
  assign stat_sel_o = aligned && (idx == IW'(SI));
endmodule

// File: rtl/phycfg_bank.sv
module phycfg_bank
  import phycfg_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic        we_i,
  input  logic [31:0] wdata_i,
  input  logic        re_i,
  output logic [31:0] rdata_o,
  input  logic        cal_done_i,
  input  logic        dll_lock_i,
  input  logic [3:0]  rtrim_code_i,
  input  logic        ext_res_absent_i,
  output logic [1:0]  freq_sel_o,
  output logic        otap_en_o,
  output logic [3:0]  otap_sel_o,
  output logic        itap_win_o,
  output logic [4:0]  itap_sel_o,
  output logic        itap_en_o,
  output logic [2:0]  clkbuf_sel_o,
  output logic        tx_dly_clk_o,
  output logic        rx_dly_clk_o,
  output logic [3:0]  strb_dly_sel_o,
  output logic        pull_en_strb_o,
  output logic        pull_en_cmd_o,
  output logic [7:0]  pull_en_dat_o,
  output logic        pull_up_strb_o,
  output logic        pull_up_cmd_o,
  output logic [7:0]  pull_up_dat_o,
  output logic        od_rel_strb_o,
  output logic        od_rel_cmd_o,
  output logic [7:0]  od_rel_dat_o,
  output logic        od_en_strb_o,
  output logic        od_en_cmd_o,
  output logic [7:0]  od_en_dat_o,
  output logic [3:0]  cp_trim_o,
  output logic        rtrim_en_o,
  output logic        retrim_o,
  output logic [2:0]  drv_type_o,
  output logic [1:0]  ret_ctl_o,
  output logic        dll_en_o,
  output logic        pwr_up_o
);
  logic [NUM_CTRL-1:0]            ctrl_sel;
  logic                           stat_sel;
  logic [NUM_CTRL-1:0][HALF-1:0]  ctrl_q;
  logic [31:0]                    status_word;
  logic [31:0]                    rd_next;

  phycfg_decode #(.AW(AW), .NC(NUM_CTRL), .SI(STAT_IDX)) u_dec (
    .addr_i     (addr_i),
    .ctrl_sel_o (ctrl_sel),
    .stat_sel_o (stat_sel)
  );

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
    localparam int W = ctrl_width(i);
    logic [W-1:0] q;
    hiword_reg #(.W(W)) u_reg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_i & ctrl_sel[i]),
      .wdata_i (wdata_i),
      .q_o     (q)
    );
    assign ctrl_q[i] = HALF'(q);
  end

  assign status_word = {25'd0, cal_done_i, dll_lock_i, rtrim_code_i, ext_res_absent_i};

  always_comb begin
    rd_next = '0;
    if (stat_sel) rd_next = status_word;
    for (int i = 0; i < NUM_CTRL; i++)
      if (ctrl_sel[i]) rd_next = {{(DW-HALF){1'b0}}, ctrl_q[i]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_next;
  end

  // offset 0x00
  assign freq_sel_o     = ctrl_q[0][13:12];
  assign otap_en_o      = ctrl_q[0][11];
  assign otap_sel_o     = ctrl_q[0][10:7];
  assign itap_win_o     = ctrl_q[0][6];
  assign itap_sel_o     = ctrl_q[0][5:1];
  assign itap_en_o      = ctrl_q[0][0];
  // offset 0x04
  assign clkbuf_sel_o   = ctrl_q[1][8:6];
  assign tx_dly_clk_o   = ctrl_q[1][5];
  assign rx_dly_clk_o   = ctrl_q[1][4];
  assign strb_dly_sel_o = ctrl_q[1][3:0];
  // offsets 0x08..0x14
  assign pull_en_strb_o = ctrl_q[2][9];
  assign pull_en_cmd_o  = ctrl_q[2][8];
  assign pull_en_dat_o  = ctrl_q[2][7:0];
  assign pull_up_strb_o = ctrl_q[3][9];
  assign pull_up_cmd_o  = ctrl_q[3][8];
  assign pull_up_dat_o  = ctrl_q[3][7:0];
  assign od_rel_cmd_o   = ctrl_q[4][9];   // swapped order at 0x10
  assign od_rel_strb_o  = ctrl_q[4][8];
  assign od_rel_dat_o   = ctrl_q[4][7:0];
  assign od_en_strb_o   = ctrl_q[5][9];
  assign od_en_cmd_o    = ctrl_q[5][8];
  assign od_en_dat_o    = ctrl_q[5][7:0];
  // offset 0x18
  assign cp_trim_o      = ctrl_q[6][12:9];
  assign rtrim_en_o     = ctrl_q[6][8];
  assign retrim_o       = ctrl_q[6][7];
  assign drv_type_o     = ctrl_q[6][6:4];
  assign ret_ctl_o      = ctrl_q[6][3:2];
  assign dll_en_o       = ctrl_q[6][1];
  assign pwr_up_o       = ctrl_q[6][0];

  a_r5_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));
  a_r4_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && |ctrl_sel) |=> rdata_o[31:16] == 16'd0);
  a_r6_status_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && stat_sel) |=> rdata_o == {25'd0, $past(cal_done_i), $past(dll_lock_i),
                                      $past(rtrim_code_i), $past(ext_res_absent_i)});
  a_r7_status_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && stat_sel) |=> $stable(ctrl_q));
  a_r8_unmapped_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !(|ctrl_sel) && !stat_sel) |=> rdata_o == 32'd0);
  a_r8_unmapped_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !(|ctrl_sel) && !stat_sel) |=> $stable(ctrl_q));
endmodule

// File: tb/phycfg_bank_tb_top.sv
module phycfg_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  addr = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cal_done = 1'b0, dll_lock = 1'b0, ext_absent = 1'b0;
  logic [3:0]  rtrim = '0;

  logic [1:0] freq_sel; logic otap_en; logic [3:0] otap_sel; logic itap_win;
  logic [4:0] itap_sel; logic itap_en;
  logic [2:0] clkbuf_sel; logic tx_dly, rx_dly; logic [3:0] strb_dly;
  logic pe_strb, pe_cmd; logic [7:0] pe_dat;
  logic pu_strb, pu_cmd; logic [7:0] pu_dat;
  logic or_strb, or_cmd; logic [7:0] or_dat;
  logic oe_strb, oe_cmd; logic [7:0] oe_dat;
  logic [3:0] cp_trim; logic rtrim_en, retrim; logic [2:0] drv_type;
  logic [1:0] ret_ctl; logic dll_en, pwr_up;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  phycfg_bank dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .re_i(re), .rdata_o(rdata), .cal_done_i(cal_done), .dll_lock_i(dll_lock),
    .rtrim_code_i(rtrim), .ext_res_absent_i(ext_absent),
    .freq_sel_o(freq_sel), .otap_en_o(otap_en), .otap_sel_o(otap_sel),
    .itap_win_o(itap_win), .itap_sel_o(itap_sel), .itap_en_o(itap_en),
    .clkbuf_sel_o(clkbuf_sel), .tx_dly_clk_o(tx_dly), .rx_dly_clk_o(rx_dly),
    .strb_dly_sel_o(strb_dly),
    .pull_en_strb_o(pe_strb), .pull_en_cmd_o(pe_cmd), .pull_en_dat_o(pe_dat),
    .pull_up_strb_o(pu_strb), .pull_up_cmd_o(pu_cmd), .pull_up_dat_o(pu_dat),
    .od_rel_strb_o(or_strb), .od_rel_cmd_o(or_cmd), .od_rel_dat_o(or_dat),
    .od_en_strb_o(oe_strb), .od_en_cmd_o(oe_cmd), .od_en_dat_o(oe_dat),
    .cp_trim_o(cp_trim), .rtrim_en_o(rtrim_en), .retrim_o(retrim),
    .drv_type_o(drv_type), .ret_ctl_o(ret_ctl), .dll_en_o(dll_en), .pwr_up_o(pwr_up)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0; d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 power-up", 32'(pwr_up), 0);
    chk("R1 dll enable", 32'(dll_en), 0);
    chk("R1 all outputs", 32'({freq_sel, otap_en, otap_sel, itap_sel, clkbuf_sel,
        pe_dat, pu_dat, or_dat, oe_dat, cp_trim, drv_type, ret_ctl}), 0);
    rd(6'h18, v); chk("R1 reg 0x18 readback", v, 0);
    rd(6'h00, v); chk("R1 reg 0x00 readback", v, 0);
  endtask

  task automatic t_reg0_map;
    logic [31:0] v;
    wr(6'h00, 32'hFFFF_2A2B);
    chk("R9 freq_sel", 32'(freq_sel), 2);
    chk("R9 otap_en", 32'(otap_en), 1);
    chk("R9 otap_sel", 32'(otap_sel), 4);
    chk("R9 itap_win", 32'(itap_win), 0);
    chk("R9 itap_sel", 32'(itap_sel), 32'h15);
    chk("R9 itap_en", 32'(itap_en), 1);
    rd(6'h00, v); chk("R4 reg 0x00 readback", v, 32'h0000_2A2B);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(6'h00, 32'h0003_0000);
    rd(6'h00, v); chk("R2 low-bit clear", v, 32'h0000_2A28);
    chk("R2 itap_sel partial", 32'(itap_sel), 32'h14);
    wr(6'h00, 32'h0000_FFFF);
    rd(6'h00, v); chk("R3 empty mask", v, 32'h0000_2A28);
    wr(6'h00, 32'h3000_FFFF);
    rd(6'h00, v); chk("R2 freq-only set", v, 32'h0000_3A28);
    chk("R2 freq_sel port", 32'(freq_sel), 3);
  endtask

  task automatic t_reg1;
    logic [31:0] v;
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, v); chk("R4 unimplemented bits zero", v, 32'h0000_01FF);
    wr(6'h04, 32'hFFFF_0095);
    chk("R12 clkbuf_sel", 32'(clkbuf_sel), 2);
    chk("R12 tx/rx delay", 32'({tx_dly, rx_dly}), 32'b01);
    chk("R12 strobe delay", 32'(strb_dly), 5);
  endtask

  task automatic t_pins;
    wr(6'h08, 32'hFFFF_0201);
    chk("R11 pull enable", 32'({pe_strb, pe_cmd, pe_dat}), 32'h201);
    wr(6'h0C, 32'hFFFF_0100);
    chk("R11 pull up", 32'({pu_strb, pu_cmd, pu_dat}), 32'h100);
    wr(6'h10, 32'hFFFF_0200);
    chk("R11 od release swapped", 32'({or_cmd, or_strb, or_dat}), 32'h200);
    chk("R11 od release strobe", 32'(or_strb), 0);
    wr(6'h14, 32'hFFFF_01A5);
    chk("R11 od enable", 32'({oe_strb, oe_cmd, oe_dat}), 32'h1A5);
  endtask

  task automatic t_reg6;
    wr(6'h18, 32'hFFFF_1E5B);
    chk("R10 cp_trim", 32'(cp_trim), 32'hF);
    chk("R10 retrim", 32'({rtrim_en, retrim}), 0);
    chk("R10 drv_type", 32'(drv_type), 5);
    chk("R10 ret_ctl", 32'(ret_ctl), 2);
    chk("R10 dll_en", 32'(dll_en), 1);
    chk("R10 pwr_up", 32'(pwr_up), 1);
  endtask

  task automatic t_status;
    logic [31:0] v;
    cal_done = 1'b1; dll_lock = 1'b0; rtrim = 4'hA; ext_absent = 1'b1;
    rd(6'h20, v); chk("R6 status word", v, 32'h0000_0055);
    cal_done = 1'b0; dll_lock = 1'b1; rtrim = 4'h3; ext_absent = 1'b0;
    rd(6'h20, v); chk("R6 status word alt", v, 32'h0000_0026);
    wr(6'h20, 32'hFFFF_0000);
    rd(6'h18, v); chk("R7 status write leaves 0x18", v, 32'h0000_1E5B);
    rd(6'h00, v); chk("R7 status write leaves 0x00", v, 32'h0000_3A28);
    chk("R7 power stays on", 32'(pwr_up), 1);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    rd(6'h1C, v); chk("R8 read 0x1C", v, 0);
    rd(6'h24, v); chk("R8 read 0x24", v, 0);
    rd(6'h01, v); chk("R8 read misaligned", v, 0);
    wr(6'h1C, 32'hFFFF_0000);
    wr(6'h02, 32'hFFFF_0000);
    wr(6'h1A, 32'hFFFF_0000);
    rd(6'h00, v); chk("R8 misaligned write ignored 0x00", v, 32'h0000_3A28);
    rd(6'h18, v); chk("R8 misaligned write ignored 0x18", v, 32'h0000_1E5B);
  endtask

  task automatic t_latency;
    logic [31:0] v;
    rd(6'h08, v); chk("R5 read value", v, 32'h0000_0201);
    @(negedge clk); addr = 6'h00;
    @(negedge clk); chk("R5 hold while idle", rdata, 32'h0000_0201);
    @(negedge clk); addr = 6'h00; wdata = 32'hFFFF_0000; we = 1'b1; re = 1'b1;
    @(negedge clk); we = 1'b0; re = 1'b0;
    chk("R5 read-during-write old value", rdata, 32'h0000_3A28);
    rd(6'h00, v); chk("R5 write landed", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_reg0_map();
    t_mask();
    t_reg1();
    t_pins();
    t_reg6();
    t_status();
    t_unmapped();
    t_latency();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule